// File: doc/BRIEF.md
# Video event interrupt controller

This block gathers three timing events from a video encoder into a single active-high interrupt line. The events are the vertical sync, the closed-caption line of field one, and the matching caption line of field two. The timing generator upstream delivers each event as a one-cycle pulse. Each pulse sets a sticky pending bit.

Software uses a small register write port and a combinational read port to control the block. It can enable each source, read the raw pending bits, and remove pending bits by writing ones to a clear location. The enable acts only on the output. A source that is disabled still records its events, and turning an enable off does not discard anything already pending. A pending bit goes away only through an explicit clear.

Register map (2-bit address): 0 = status (read only), 1 = enable (read/write), 2 = clear (write only, reads as zero), 3 = unused. Bit positions in every register are: bit 0 vertical sync, bit 1 field-one caption line, bit 2 field-two caption line.

Top module: `vid_evt_irq`

## Requirements
- R1: After reset, all pending bits are 0, the enable register reads 0, and `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[n]` sets pending bit n on that clock edge whatever the enable state. Reading address 0 returns the pending bits in data bits 2:0, with bit 0 = vertical sync, bit 1 = field-one caption line and bit 2 = field-two caption line.
- R3: A pending bit stays set across later cycles with no event, until it is cleared.
- R4: Writing address 2 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R5: Writing address 1 loads data bits 2:0 into the enable register. Reading address 1 returns them.
- R6: `irq_o` is high exactly when at least one source is both pending and enabled.
- R7: Clearing an enable bit drops that source's contribution to `irq_o` but keeps its pending bit. Re-enabling raises `irq_o` again.
- R8: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up pending.
- R9: Writes to address 0 or 3 change no state. Data bits above bit 2 are ignored. Reading address 2 or 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 3 | Event pulses: bit 0 vertical sync, bit 1 field-one caption line, bit 2 field-two caption line |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data, combinational from the read address |
| irq_o | output | 1 | Interrupt, active high |

## Verification
Two functions can land on the same bit in the same cycle: capture of an event pulse, and a write-one clear of that bit. The bench provokes this by raising the event bit in the same cycle as the clear write to that bit. It then reads the status after the edge and expects the bit to still be set. In the same write it clears a different pending bit, which shows that the clear path itself worked and that only the colliding bit survived.

// File: rtl/vint_pkg.sv
package vint_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_VSYNC = 2'd0,
    SRC_CC_F1 = 2'd1,
    SRC_CC_F2 = 2'd2
  } vint_src_e;

  localparam int ADDR_STAT = 0;
  localparam int ADDR_EN   = 1;
  localparam int ADDR_CLR  = 2;
endpackage

// File: rtl/vint_pend_cell.sv
module vint_pend_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  input  logic en_i,
  output logic pend_o,
  output logic req_o
);
  logic pend_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= evt_i | (pend_q & ~clr_i);
  end

  assign pend_o = pend_q;
  assign req_o  = pend_q & en_i;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> pend_q);
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !pend_q);
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt_i) |=> pend_q);
  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && !evt_i) |=> !pend_q);
endmodule

// File: rtl/vint_regs.sv
module vint_regs
  import vint_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  input  logic [NSRC-1:0] pend_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] clr_o,
  output logic [DW-1:0]   rd_data_o
);
  logic [NSRC-1:0] en_q;
  logic            wr_en_hit;
  logic            wr_clr_hit;

  assign wr_en_hit  = wr_en_i && (wr_addr_i == AW'(ADDR_EN));
  assign wr_clr_hit = wr_en_i && (wr_addr_i == AW'(ADDR_CLR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= '0;
    else if (wr_en_hit) en_q <= wr_data_i[NSRC-1:0];
  end

  assign clr_o = wr_clr_hit ? wr_data_i[NSRC-1:0] : '0;
  assign en_o  = en_q;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(ADDR_STAT))    rd_data_o = DW'(pend_i);
    else if (rd_addr_i == AW'(ADDR_EN)) rd_data_o = DW'(en_q);
  end

  p_en_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_hit |=> $stable(en_q));
  p_en_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_hit |=> (en_q == $past(wr_data_i[NSRC-1:0])));
  p_clr_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (clr_o == '0));
endmodule

// File: rtl/vid_evt_irq.sv
module vid_evt_irq
  import vint_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            irq_o
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] clr;
  logic [NSRC-1:0] req;

  vint_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .pend_i    (pend),
    .en_o      (en),
    .clr_o     (clr),
    .rd_data_o (rd_data_o)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    vint_pend_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_i[i]),
      .clr_i  (clr[i]),
      .en_i   (en[i]),
      .pend_o (pend[i]),
      .req_o  (req[i])
    );
  end

  assign irq_o = |req;

  p_irq_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend & en) != '0));
  p_irq_need_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & en) != '0) |-> irq_o);
  p_no_irq_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> !irq_o);
endmodule

// File: tb/sim_vid_evt_irq.sv
module sim_vid_evt_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  vid_evt_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [1:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic cyc(logic [2:0] e, logic w, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    evt = e; wr_en = w; wr_addr = a; wr_data = d;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    rd("R1", 2'd0, 8'h00);
    rd("R1", 2'd1, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_enable;
    cyc(3'b000, 1'b1, 2'd1, 8'h05);
    rd("R5", 2'd1, 8'h05);
    cyc(3'b000, 1'b1, 2'd1, 8'hFA);
    rd("R9", 2'd1, 8'h02);
    cyc(3'b000, 1'b1, 2'd1, 8'h00);
    rd("R5", 2'd1, 8'h00);
  endtask

  task automatic t_capture;
    cyc(3'b001, 1'b0, 2'd0, 8'h00);
    rd("R2", 2'd0, 8'h01);
    chk("R6", {7'd0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    rd("R3", 2'd0, 8'h01);
    cyc(3'b100, 1'b0, 2'd0, 8'h00);
    rd("R2", 2'd0, 8'h05);
  endtask

  task automatic t_irq;
    cyc(3'b000, 1'b1, 2'd1, 8'h02);
    chk("R6", {7'd0, irq}, 8'h00);
    cyc(3'b000, 1'b1, 2'd1, 8'h04);
    chk("R6", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_disable_keep;
    cyc(3'b000, 1'b1, 2'd1, 8'h00);
    chk("R7", {7'd0, irq}, 8'h00);
    rd("R7", 2'd0, 8'h05);
    cyc(3'b000, 1'b1, 2'd1, 8'h01);
    chk("R7", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_clear;
    cyc(3'b000, 1'b1, 2'd2, 8'h00);
    rd("R4", 2'd0, 8'h05);
    cyc(3'b000, 1'b1, 2'd2, 8'h01);
    rd("R4", 2'd0, 8'h04);
    chk("R6", {7'd0, irq}, 8'h00);
    cyc(3'b000, 1'b1, 2'd2, 8'hF4);
    rd("R4", 2'd0, 8'h00);
  endtask

  task automatic t_collide;
    cyc(3'b001, 1'b0, 2'd0, 8'h00);
    cyc(3'b010, 1'b1, 2'd2, 8'h03);
    rd("R8", 2'd0, 8'h02);
    cyc(3'b000, 1'b1, 2'd2, 8'h02);
    rd("R4", 2'd0, 8'h00);
  endtask

  task automatic t_other_addr;
    cyc(3'b010, 1'b0, 2'd0, 8'h00);
    cyc(3'b000, 1'b1, 2'd3, 8'hFF);
    cyc(3'b000, 1'b1, 2'd0, 8'h00);
    rd("R9", 2'd0, 8'h02);
    rd("R9", 2'd1, 8'h01);
    rd("R9", 2'd2, 8'h00);
    rd("R9", 2'd3, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_enable;
    t_capture;
    t_irq;
    t_disable_keep;
    t_clear;
    t_collide;
    t_other_addr;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule